// File: doc/BRIEF.md
# Serial Command Bus Master Bridge

This block lets an external host reach the system bus over a plain asynchronous serial link, with no processor involved. A receiver delivers bytes one at a time. The bridge parses each command from that stream and issues single-word bus reads or writes as a bus master. For reads, it returns the data through a byte-wide transmitter interface.

A command starts with one control byte. Four address bytes follow. For a write, one data word of four bytes follows for every word in the command. A command can cover up to 64 consecutive words, and the bus address steps by four after each word. A read command carries no data. Each word read is sent back over the transmitter as soon as its bus access completes, and the next read starts only after that. If a command stalls part-way through, an idle timer drops it, so the host can always resynchronise by waiting and then sending a fresh control byte.

Top module: `dbg_uart_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_req` and `tx_valid` are low, and the parser waits for a control byte.
- R2: In the control byte, bit 7 set means write and clear means read. Bits 5:0 hold the number of words minus one. Bit 6 has no effect.
- R3: The four bytes after the control byte form the start address, most significant byte first.
- R4: A write sends four data bytes per word, most significant first. After the fourth byte the bridge issues a bus access with `bus_we` high and that word on `bus_wdata`.
- R5: A read issues its first bus access with `bus_we` low right after the fourth address byte, and takes no data bytes.
- R6: In a command of several words, each bus access uses the previous address plus 4.
- R7: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` unchanged, until a cycle in which `bus_ack` is high.
- R8: Each word read is returned on the transmitter as four bytes, most significant first, after its bus access is acknowledged. The next read access begins only after the fourth byte is accepted.
- R9: Once `tx_valid` is high it stays high, with `tx_data` unchanged, until `tx_ready` is high.
- R10: `bus_req` and `tx_valid` are never high in the same cycle.
- R11: If `IDLE_LIMIT` cycles pass with no byte while an address or a write data word is incomplete, the partial command is dropped and the next byte is taken as a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte offered |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| tx_data | output | 8 | Response byte |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Word address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The assertions assume three things about the inputs:
- `bus_ack` is raised only while `bus_req` is high.
- `bus_rdata` is valid in the cycle of `bus_ack`.
- No received byte arrives while a bus access or a read response is in progress, because such bytes are dropped.

The stimulus spaces received bytes several cycles apart, and this gap is longer than a bus access. It waits until every expected bus access and response byte has been seen before sending the next command. Bus acknowledges come after a fixed delay. Transmitter readiness is withheld on one cycle in three, so response bytes are stalled mid-word.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BIDX_W     = $clog2(WORD_BYTES);
    localparam int WCNT_W     = 6;

    typedef enum logic [2:0] {
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_BUS,
        ST_RESP
    } bridge_state_e;

    typedef struct packed {
        logic              is_write;
        logic [WCNT_W-1:0] words_m1;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.is_write = b[7];
        c.words_m1 = b[WCNT_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a);
        return a + WORD_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/dbg_byte_gather.sv
module dbg_byte_gather #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] word_out
);
    localparam int GW = W - 8;

    logic [GW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (shift_en)
            held_q <= {held_q[GW-9:0], byte_in};
    end

    assign word_out = {held_q, byte_in};
endmodule

// File: rtl/dbg_idle_timer.sv
module dbg_idle_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !armed || kick)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = armed && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/dbg_tx_ser.sv
module dbg_tx_ser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [7:0]   tx_data,
    output logic         last_sent
);
    localparam int NB = W / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [W-1:0]  sh_q;
    logic [IW-1:0] idx_q;
    logic          vld_q;
    logic          take;

    assign take      = vld_q && tx_ready;
    assign last_sent = take && (idx_q == IW'(NB - 1));
    assign tx_valid  = vld_q;
    assign tx_data   = sh_q[W-1 -: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else if (load) begin
            sh_q  <= word_in;
            idx_q <= '0;
            vld_q <= 1'b1;
        end else if (take) begin
            sh_q  <= {sh_q[W-9:0], 8'h00};
            idx_q <= idx_q + 1'b1;
            if (last_sent)
                vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_uart_bridge.sv
module dbg_uart_bridge
    import dbg_uart_pkg::*;
#(
    parameter int IDLE_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(WORD_BYTES - 1);

    bridge_state_e     state_q;
    ctrl_t             ctrl_q;
    logic [WCNT_W-1:0] left_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    logic              collecting;
    logic              byte_in;
    logic              idle_exp;
    logic [WORD_W-1:0] gathered;
    logic              ser_load;
    logic              ser_done;

    assign collecting = (state_q == ST_ADDR) || (state_q == ST_WDATA);
    assign byte_in    = collecting && rx_valid;
    assign ser_load   = (state_q == ST_BUS) && bus_ack && !ctrl_q.is_write;

    dbg_byte_gather #(.W(WORD_W)) gather_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (byte_in),
        .byte_in  (rx_data),
        .word_out (gathered)
    );

    dbg_idle_timer #(.LIMIT(IDLE_LIMIT)) idle_i (
        .clk     (clk),
        .rst     (rst),
        .armed   (collecting),
        .kick    (rx_valid),
        .expired (idle_exp)
    );

    dbg_tx_ser #(.W(WORD_W)) ser_i (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .word_in   (bus_rdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .last_sent (ser_done)
    );

    assign bus_req   = (state_q == ST_BUS);
    assign bus_we    = ctrl_q.is_write;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CTRL;
            ctrl_q  <= '0;
            left_q  <= '0;
            bidx_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_CTRL: begin
                    if (rx_valid) begin
                        ctrl_q  <= decode_ctrl(rx_data);
                        left_q  <= decode_ctrl(rx_data).words_m1;
                        bidx_q  <= '0;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (idle_exp) begin
                        state_q <= ST_CTRL;
                    end else if (rx_valid) begin
                        bidx_q <= (bidx_q == LAST_IDX) ? '0 : bidx_q + 1'b1;
                        if (bidx_q == LAST_IDX) begin
                            addr_q  <= gathered;
                            state_q <= ctrl_q.is_write ? ST_WDATA : ST_BUS;
                        end
                    end
                end
                ST_WDATA: begin
                    if (idle_exp) begin
                        state_q <= ST_CTRL;
                    end else if (rx_valid) begin
                        bidx_q <= (bidx_q == LAST_IDX) ? '0 : bidx_q + 1'b1;
                        if (bidx_q == LAST_IDX) begin
                            wdata_q <= gathered;
                            state_q <= ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        if (!ctrl_q.is_write) begin
                            state_q <= ST_RESP;
                        end else if (left_q == '0) begin
                            state_q <= ST_CTRL;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            addr_q  <= step_addr(addr_q);
                            state_q <= ST_WDATA;
                        end
                    end
                end
                ST_RESP: begin
                    if (ser_done) begin
                        if (left_q == '0) begin
                            state_q <= ST_CTRL;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            addr_q  <= step_addr(addr_q);
                            state_q <= ST_BUS;
                        end
                    end
                end
                default: state_q <= ST_CTRL;
            endcase
        end
    end
endmodule

// File: rtl/dbg_uart_bridge_chk.sv
module dbg_uart_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data
);
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!bus_req && !tx_valid));

    assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && tx_valid));
endmodule

bind dbg_uart_bridge dbg_uart_bridge_chk chk_i (.*);

// File: tb/dbg_uart_bridge_tb_top.sv
module dbg_uart_bridge_tb_top;
    localparam int LIMIT = 40;
    localparam int GAP   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = 32'h0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int lat     = 0;

    logic        exp_we[$];
    logic [31:0] exp_addr[$];
    logic [31:0] exp_wd[$];
    logic [7:0]  exp_tx[$];

    always #2 clk = ~clk;

    dbg_uart_bridge #(.IDLE_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor and responder: bus slave with 2-cycle latency, stalling transmitter.
    always @(negedge clk) begin
        cyc++;
        tx_ready = (cyc % 3) != 0;
        if (!rst && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                check(0, "R8 unexpected tx byte", {24'h0, tx_data}, 32'h0);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                check(tx_data == e, "R8 tx byte order", {24'h0, tx_data}, {24'h0, e});
            end
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
            lat = 0;
        end else if (!rst && bus_req) begin
            lat++;
            if (lat >= 2) begin
                if (exp_addr.size() == 0) begin
                    check(0, "R5 unexpected bus access", bus_addr, 32'h0);
                end else begin
                    logic        ew;
                    logic [31:0] ea;
                    logic [31:0] ed;
                    ew = exp_we.pop_front();
                    ea = exp_addr.pop_front();
                    ed = exp_wd.pop_front();
                    check(bus_we == ew, "R2 access direction", {31'h0, bus_we}, {31'h0, ew});
                    check(bus_addr == ea, "R3 R6 access address", bus_addr, ea);
                    if (ew)
                        check(bus_wdata == ed, "R4 write data", bus_wdata, ed);
                end
                bus_ack = 1'b1;
                bus_rdata = mem_model(bus_addr);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            finish_run();
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_addr.size() != 0 || exp_tx.size() != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] ctrl, input logic [31:0] a,
                            input logic [31:0] seed);
        int n = int'(ctrl[5:0]) + 1;
        for (int i = 0; i < n; i++) begin
            exp_we.push_back(1'b1);
            exp_addr.push_back(a + 32'(4 * i));
            exp_wd.push_back(seed + 32'(i) * 32'h0101_0101);
        end
        send_byte(ctrl);
        send_word(a);
        for (int i = 0; i < n; i++) send_word(seed + 32'(i) * 32'h0101_0101);
        drain();
    endtask

    task automatic do_read(input logic [7:0] ctrl, input logic [31:0] a);
        int n = int'(ctrl[5:0]) + 1;
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            d = mem_model(a + 32'(4 * i));
            exp_we.push_back(1'b0);
            exp_addr.push_back(a + 32'(4 * i));
            exp_wd.push_back(32'h0);
            for (int k = 3; k >= 0; k--) exp_tx.push_back(d[k*8 +: 8]);
        end
        send_byte(ctrl);
        send_word(a);
        drain();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: idle during reset
        check(!bus_req && !tx_valid, "R1 reset idle", {31'h0, bus_req | tx_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !tx_valid, "R1 idle after reset", {31'h0, bus_req | tx_valid}, 32'h0);

        // R2 R3 R4: single-word write
        do_write(8'h80, 32'h1000_0004, 32'hDEAD_BEEF);
        // R5 R8: single-word read
        do_read(8'h00, 32'h2000_0010);
        // R6: three-word write
        do_write(8'h82, 32'h3000_0000, 32'h1122_3344);
        // R6 R8 R9: four-word read with transmitter stalls
        do_read(8'h03, 32'h4000_0100);
        // R2: bit 6 has no effect
        do_write(8'hC0, 32'h0BAD_F00C, 32'hCAFE_0001);
        do_read(8'h41, 32'h6000_0020);

        // R11: stalled partial address is dropped after the idle limit
        send_byte(8'h00);
        send_byte(8'h12);
        send_byte(8'h34);
        repeat (LIMIT + 10) @(negedge clk);
        check(!bus_req, "R11 no access from dropped command", {31'h0, bus_req}, 32'h0);
        do_read(8'h00, 32'h5000_0008);

        // R11: stalled partial write data is dropped as well
        send_byte(8'h80);
        send_word(32'h7000_0000);
        send_byte(8'hAA);
        repeat (LIMIT + 10) @(negedge clk);
        check(!bus_req, "R11 no write from dropped data", {31'h0, bus_req}, 32'h0);
        do_write(8'h80, 32'h7000_0040, 32'h0F0F_0F0F);

        check(exp_addr.size() == 0, "R4 R5 all bus accesses seen",
              32'(exp_addr.size()), 32'h0);
        check(exp_tx.size() == 0, "R8 all response bytes seen",
              32'(exp_tx.size()), 32'h0);
        finish_run();
    end
endmodule